// File: doc/BRIEF.md
# Erased Sector Parity Filter

This block sits beside a Reed-Solomon engine that protects each 512-byte flash sector with 9 parity bytes. It deals only with the erased-sector case and does no Reed-Solomon arithmetic. A freshly erased sector reads back as all ones. Its true parity is a fixed 9-byte value. If that value were written into the spare area, later partial writes to the same page would break. The encode path therefore watches the 9 parity bytes the engine produces. If they are exactly the erased-sector parity, it replaces them with nine 0xFF bytes. Any other parity goes out unchanged.

The decode path takes the stored sector as one byte stream: the 9 parity bytes first (stream positions 0 to 8), then the 512 data bytes (positions 9 to 520). It decides whether the whole sector is still erased. If it is, the decoder can be skipped, and the sector reports zero corrections. The first byte that is not 0xFF rejects the sector at once. A `dec_pass` pulse tells the caller to run the real decoder, and the rest of that sector's bytes are consumed without being compared. A `sector_start` pulse clears both paths so that a new sector can begin.

The encoder has two states. In ENC_GATHER it stores bytes and tracks the match. The transition gather-to-emit happens on the ninth byte. In ENC_EMIT it sends out one byte per cycle. The transition emit-to-gather happens after the ninth output byte. The decoder has three states: DEC_PARITY, DEC_DATA and DEC_DRAIN. Its transitions are:
- parity-to-data, after stream byte 8;
- check-to-drain, on a bad byte;
- any state back to DEC_PARITY, after byte 520 or on `sector_start`.

Top module: `erased_sector_filter`

## Requirements
- R1: After reset, `enc_out_valid`, `dec_skip` and `dec_pass` are all low.
- R2: When the 9 encode input bytes, in arrival order, equal CD 9D 90 58 F4 8B FF B7 6F, the block emits nine 0xFF bytes. They come on consecutive cycles, and the first is valid in the cycle after the ninth input byte is sampled.
- R3: When any of the 9 encode input bytes differs from that sequence, the same 9 bytes are emitted in arrival order, with the same timing as R2.
- R4: Encode input bytes presented while the 9 output bytes are being emitted are ignored. The following group of 9 input bytes is handled as a fresh group.
- R5: A decode sector in which all 521 bytes are 0xFF produces a one-cycle `dec_skip` pulse in the cycle after byte 520 is sampled. Idle cycles with `dec_in_valid` low may occur anywhere in the stream.
- R6: If stream byte 0 (parity byte 0) is not 0xFF, `dec_pass` pulses in the cycle after that byte.
- R7: Any later byte that is not 0xFF also gives a `dec_pass` pulse in the following cycle. This includes data bytes 0, 256 and 511, which are stream positions 9, 265 and 520. The remaining bytes of that sector then give no pulse, and the next sector starts after byte 520.
- R8: `dec_skip` and `dec_pass` are never high in the same cycle, and at most one of them pulses per sector.
- R9: `sector_start` returns both paths to their first byte and drops any byte presented in the same cycle. No output is active in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sector_start | input | 1 | Clears both paths for a new sector |
| enc_in_valid | input | 1 | Computed parity byte is valid |
| enc_in_byte | input | 8 | Computed parity byte from the encoder |
| enc_out_valid | output | 1 | Filtered parity byte is valid |
| enc_out_byte | output | 8 | Filtered parity byte to be written |
| dec_in_valid | input | 1 | Stored byte is valid |
| dec_in_byte | input | 8 | Stored byte: 9 parity bytes, then 512 data bytes |
| dec_skip | output | 1 | Pulse: sector erased, bypass the decoder |
| dec_pass | output | 1 | Pulse: sector not erased, run the decoder |

## Verification
Suppose the decode position counter is off by even one byte. Then the skip pulse for an erased sector arrives a cycle early or late, or a reject lands in the wrong sector. The bench checks the exact cycle of every pulse, so such a fault shows within one sector of 521 bytes. A stuck or stale encode match flag turns the next group's nine output bytes into 0xFF, or leaves them unchanged, within 10 cycles of its ninth input. A drain state that fails to clear shows up as a missing skip on the following erased sector.

// File: rtl/epf_pkg.sv
package epf_pkg;
    localparam int BYTE_W     = 8;
    localparam int PAR_BYTES  = 9;
    localparam int DATA_BYTES = 512;
    localparam logic [BYTE_W-1:0] ALL_ONES = 8'hFF;

    typedef enum logic {ENC_GATHER, ENC_EMIT} enc_state_e;
    typedef enum logic [1:0] {DEC_PARITY, DEC_DATA, DEC_DRAIN} dec_state_e;

    // Parity of a sector whose data bytes are all ones, by parity position
    function automatic logic [BYTE_W-1:0] erased_par(input logic [3:0] pos);
        case (pos)
            4'd0:    return 8'hCD;
            4'd1:    return 8'h9D;
            4'd2:    return 8'h90;
            4'd3:    return 8'h58;
            4'd4:    return 8'hF4;
            4'd5:    return 8'h8B;
            4'd6:    return 8'hFF;
            4'd7:    return 8'hB7;
            4'd8:    return 8'h6F;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/epf_enc.sv
module epf_enc
    import epf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte
);
    localparam int IDX_W = $clog2(PAR_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAR_BYTES - 1);

    enc_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic              match_q;
    logic [BYTE_W-1:0] hold_q [PAR_BYTES];

    // State register, position counter and running match flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENC_GATHER;
            idx_q   <= '0;
            match_q <= 1'b1;
        end else if (start) begin
            state_q <= ENC_GATHER;
            idx_q   <= '0;
            match_q <= 1'b1;
        end else begin
            unique case (state_q)
                ENC_GATHER: begin
                    if (in_valid) begin
                        match_q <= match_q && (in_byte == erased_par(4'(idx_q)));
                        if (idx_q == IDX_LAST) begin
                            idx_q   <= '0;
                            state_q <= ENC_EMIT;    // gather-to-emit
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ENC_EMIT: begin
                    if (idx_q == IDX_LAST) begin
                        idx_q   <= '0;
                        match_q <= 1'b1;
                        state_q <= ENC_GATHER;      // emit-to-gather
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ENC_GATHER;
            endcase
        end
    end

    // Byte store, no reset needed
    always_ff @(posedge clk) begin
        if (!start && state_q == ENC_GATHER && in_valid)
            hold_q[idx_q] <= in_byte;
    end

    // Outputs
    always_comb begin
        out_valid = (state_q == ENC_EMIT);
        out_byte  = match_q ? ALL_ONES : hold_q[idx_q];
    end

    // R2: emission begins only right after an accepted input byte
    a_r2_emit_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> ($past(in_valid) && !$past(start)));

    // R4: the match decision does not move while bytes are emitted
    a_r4_match_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENC_EMIT && idx_q != IDX_LAST && !start) |=> $stable(match_q));

    // R2: a burst is not cut short without a start pulse
    a_r2_burst_whole: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && idx_q != IDX_LAST && !start) |=> out_valid);
endmodule

// File: rtl/epf_dec.sv
module epf_dec
    import epf_pkg::*;
#(
    parameter int N_DATA = DATA_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              skip,
    output logic              pass
);
    localparam int TOTAL = PAR_BYTES + N_DATA;
    localparam int CNT_W = $clog2(TOTAL);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TOTAL - 1);
    localparam logic [CNT_W-1:0] PAR_LAST = CNT_W'(PAR_BYTES - 1);

    dec_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             skip_q;
    logic             pass_q;
    logic             at_last;
    logic             bad;

    always_comb begin
        at_last = (cnt_q == CNT_LAST);
        bad     = (in_byte != ALL_ONES);
    end

    // State register, stream position and result pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DEC_PARITY;
            cnt_q   <= '0;
            skip_q  <= 1'b0;
            pass_q  <= 1'b0;
        end else if (start) begin
            state_q <= DEC_PARITY;
            cnt_q   <= '0;
            skip_q  <= 1'b0;
            pass_q  <= 1'b0;
        end else begin
            skip_q <= 1'b0;
            pass_q <= 1'b0;
            if (in_valid) begin
                cnt_q <= at_last ? '0 : cnt_q + 1'b1;
                unique case (state_q)
                    DEC_PARITY: begin
                        if (bad) begin
                            pass_q  <= 1'b1;
                            state_q <= DEC_DRAIN;           // check-to-drain
                        end else if (cnt_q == PAR_LAST) begin
                            state_q <= DEC_DATA;            // parity-to-data
                        end
                    end
                    DEC_DATA: begin
                        if (bad) begin
                            pass_q  <= 1'b1;
                            state_q <= at_last ? DEC_PARITY : DEC_DRAIN;
                        end else if (at_last) begin
                            skip_q  <= 1'b1;
                            state_q <= DEC_PARITY;          // sector end
                        end
                    end
                    DEC_DRAIN: begin
                        if (at_last) state_q <= DEC_PARITY; // drain end
                    end
                    default: state_q <= DEC_PARITY;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        skip = skip_q;
        pass = pass_q;
    end

    // R8: verdicts exclusive
    a_r8_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        !(skip && pass));

    // R5: skip only after an all-ones byte was taken
    a_r5_skip_after_ones: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> ($past(in_valid) && $past(in_byte) == ALL_ONES));

    // R6: pass only after a byte that was not all ones
    a_r6_pass_after_bad: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> ($past(in_valid) && $past(in_byte) != ALL_ONES));

    // R7: draining never raises a verdict
    a_r7_drain_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DEC_DRAIN) |=> (!skip && !pass));

    // R5: skip is a single-cycle pulse
    a_r5_skip_single: assert property (@(posedge clk) disable iff (!rst_n)
        skip |=> !skip);
endmodule

// File: rtl/erased_sector_filter.sv
module erased_sector_filter
    import epf_pkg::*;
#(
    parameter int N_DATA = DATA_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sector_start,
    input  logic              enc_in_valid,
    input  logic [BYTE_W-1:0] enc_in_byte,
    output logic              enc_out_valid,
    output logic [BYTE_W-1:0] enc_out_byte,
    input  logic              dec_in_valid,
    input  logic [BYTE_W-1:0] dec_in_byte,
    output logic              dec_skip,
    output logic              dec_pass
);
    epf_enc u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sector_start),
        .in_valid  (enc_in_valid),
        .in_byte   (enc_in_byte),
        .out_valid (enc_out_valid),
        .out_byte  (enc_out_byte)
    );

    epf_dec #(.N_DATA(N_DATA)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (sector_start),
        .in_valid (dec_in_valid),
        .in_byte  (dec_in_byte),
        .skip     (dec_skip),
        .pass     (dec_pass)
    );

    // R9: a start pulse leaves every output quiet in the next cycle
    a_r9_start_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sector_start) |-> (!enc_out_valid && !dec_skip && !dec_pass));
endmodule

// File: tb/erased_sector_filter_bench.sv
module erased_sector_filter_bench;
    localparam logic [71:0] ERASED_PAR = 72'h6F_B7_FF_8B_F4_58_90_9D_CD;
    localparam int SECTOR = 521;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sector_start = 1'b0;
    logic       enc_in_valid = 1'b0;
    logic [7:0] enc_in_byte = 8'h00;
    logic       enc_out_valid;
    logic [7:0] enc_out_byte;
    logic       dec_in_valid = 1'b0;
    logic [7:0] dec_in_byte = 8'h00;
    logic       dec_skip;
    logic       dec_pass;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    logic [7:0] enc_b_q[$];
    int         enc_c_q[$];
    string      enc_r_q[$];
    int         dec_k_q[$];   // 1 = skip, 0 = pass
    int         dec_c_q[$];
    string      dec_r_q[$];

    always #10 clk = ~clk;

    erased_sector_filter u_erased_sector_filter (
        .clk(clk), .rst_n(rst_n), .sector_start(sector_start),
        .enc_in_valid(enc_in_valid), .enc_in_byte(enc_in_byte),
        .enc_out_valid(enc_out_valid), .enc_out_byte(enc_out_byte),
        .dec_in_valid(dec_in_valid), .dec_in_byte(dec_in_byte),
        .dec_skip(dec_skip), .dec_pass(dec_pass)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compares design results against the scoreboard queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (enc_out_valid) begin
                if (enc_b_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected encode byte", enc_out_byte, 0);
                end else begin
                    logic [7:0] eb;
                    int ec;
                    string er;
                    eb = enc_b_q.pop_front();
                    ec = enc_c_q.pop_front();
                    er = enc_r_q.pop_front();
                    check(enc_out_byte == eb, er, "encode byte", enc_out_byte, eb);
                    check(cyc == ec, er, "encode byte cycle", cyc, ec);
                end
            end
            if (dec_skip && dec_pass) begin
                check(1'b0, "R8", "skip and pass together", 3, 0);
            end else if (dec_skip || dec_pass) begin
                if (dec_k_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected verdict (1=skip)", int'(dec_skip), 2);
                end else begin
                    int dk;
                    int dc;
                    string dr;
                    dk = dec_k_q.pop_front();
                    dc = dec_c_q.pop_front();
                    dr = dec_r_q.pop_front();
                    check(int'(dec_skip) == dk, dr, "verdict kind (1=skip)", int'(dec_skip), dk);
                    check(cyc == dc, dr, "verdict cycle", cyc, dc);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc == 60000) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Encode driver: pushes expected bytes before the ninth input is sampled
    task automatic enc_send(input logic [71:0] v, input string req, input bit junk);
        bit hit;
        hit = (v == ERASED_PAR);
        for (int k = 0; k < 9; k++) begin
            if (k == 8) begin
                for (int j = 0; j < 9; j++) begin
                    enc_b_q.push_back(hit ? 8'hFF : v[8*j +: 8]);
                    enc_c_q.push_back(cyc + 1 + j);
                    enc_r_q.push_back(req);
                end
            end
            enc_in_valid = 1'b1;
            enc_in_byte  = v[8*k +: 8];
            @(negedge clk);
        end
        if (junk) begin
            for (int k = 0; k < 9; k++) begin
                enc_in_valid = 1'b1;
                enc_in_byte  = 8'(k * 37 + 3);
                @(negedge clk);
            end
        end
        enc_in_valid = 1'b0;
        idle(junk ? 2 : 11);
    endtask

    // Decode driver: bytes at bad_a / bad_b are 0xFE, the rest 0xFF
    task automatic dec_send(input int bad_a, input int bad_b, input bit gaps, input string req);
        for (int i = 0; i < SECTOR; i++) begin
            if (gaps && (i % 7 == 3)) begin
                dec_in_valid = 1'b0;
                @(negedge clk);
            end
            if ((bad_a >= 0 && i == bad_a) || (bad_a < 0 && i == SECTOR - 1)) begin
                dec_k_q.push_back(bad_a < 0 ? 1 : 0);
                dec_c_q.push_back(cyc + 1);
                dec_r_q.push_back(req);
            end
            dec_in_valid = 1'b1;
            dec_in_byte  = (i == bad_a || i == bad_b) ? 8'hFE : 8'hFF;
            @(negedge clk);
        end
        dec_in_valid = 1'b0;
        idle(3);
    endtask

    task automatic pulse_start();
        sector_start = 1'b1;
        @(negedge clk);
        sector_start = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        check(!enc_out_valid, "R1", "enc_out_valid after reset", int'(enc_out_valid), 0);
        check(!dec_skip, "R1", "dec_skip after reset", int'(dec_skip), 0);
        check(!dec_pass, "R1", "dec_pass after reset", int'(dec_pass), 0);

        // R2: erased parity becomes all ones
        enc_send(ERASED_PAR, "R2", 1'b0);
        // R3: mismatches pass through (random, last byte off, first byte off)
        enc_send(72'h11_EF_CD_AB_89_67_45_23_01, "R3", 1'b0);
        enc_send(ERASED_PAR ^ 72'h01_00_00_00_00_00_00_00_00, "R3", 1'b0);
        enc_send(ERASED_PAR ^ 72'h00_00_00_00_00_00_00_00_80, "R3", 1'b0);
        // R4: junk during emission ignored, next group fresh
        enc_send(ERASED_PAR, "R4", 1'b1);
        enc_send(72'h00_00_00_00_00_00_00_00_00, "R4", 1'b1);
        enc_send(ERASED_PAR, "R4", 1'b0);

        // R5: erased sectors, back to back and with gaps
        dec_send(-1, -1, 1'b0, "R5");
        dec_send(-1, -1, 1'b1, "R5");
        // R6: parity byte 0 bad
        dec_send(0, -1, 1'b0, "R6");
        // R7: quick-reject positions and a later bad byte ignored
        dec_send(9, 300, 1'b0, "R7");
        dec_send(265, 520, 1'b1, "R7");
        dec_send(520, -1, 1'b0, "R7");
        dec_send(8, 12, 1'b0, "R7");
        dec_send(-1, -1, 1'b0, "R7");

        // R9: start clears a partial encode group
        for (int k = 0; k < 4; k++) begin
            enc_in_valid = 1'b1;
            enc_in_byte  = 8'h00;
            @(negedge clk);
        end
        enc_in_valid = 1'b0;
        pulse_start();
        enc_send(ERASED_PAR, "R9", 1'b0);
        // R9: start clears a partial decode sector
        for (int k = 0; k < 100; k++) begin
            dec_in_valid = 1'b1;
            dec_in_byte  = 8'hFF;
            @(negedge clk);
        end
        dec_in_valid = 1'b0;
        pulse_start();
        dec_send(-1, -1, 1'b0, "R9");
        // R9: a byte presented with start is dropped
        sector_start = 1'b1;
        dec_in_valid = 1'b1;
        dec_in_byte  = 8'h00;
        enc_in_valid = 1'b1;
        enc_in_byte  = 8'h00;
        @(negedge clk);
        sector_start = 1'b0;
        dec_in_valid = 1'b0;
        enc_in_valid = 1'b0;
        check(!dec_pass && !enc_out_valid, "R9", "outputs after start", int'(dec_pass), 0);
        dec_send(-1, -1, 1'b0, "R9");
        enc_send(ERASED_PAR, "R9", 1'b0);

        idle(20);
        check(enc_b_q.size() == 0, "R2", "encode bytes outstanding", enc_b_q.size(), 0);
        check(dec_k_q.size() == 0, "R5", "verdicts outstanding", dec_k_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule